// File: doc/BRIEF.md
# Per-Core Performance Monitor

This block counts what a processor core is doing. It holds one 32-bit cycle counter and four 32-bit event counters. Each event counter watches one line of an event input vector, picked by an 8-bit code. It adds one for every clock in which that line is high. Software programs and reads the counters over a simple word-addressed register bus. Each bus access carries a privilege flag.

Event counting is allowed only while at least one of two debug-authentication inputs is high. The cycle counter does not depend on those inputs, unless software sets a control bit that stops it too while counting is prohibited. The levels of the two authentication inputs can be read back, so software can find out why events are not counting.

An unprivileged access is refused unless software has enabled user access. A refused access raises a fault flag for that access and changes nothing. The event counters are reached through a select register, so one address window serves all of them.

Top module: `perfmon_unit`

Register word addresses on `bus_addr`:
- 0: control
- 1: count-enable set
- 2: count-enable clear
- 3: counter select
- 4: event type
- 5: event count
- 6: cycle count
- 7: user-access enable
- 8: overflow status
- 9: authentication status

Any other address reads zero and ignores writes.

## Requirements
- R1: After reset every register and counter is zero, `bus_ack` is low, and reads of control, count-enable, cycle count, event count and overflow status all return 0.
- R2: In the count-enable set (address 1) and clear (address 2) registers, bit 31 is the cycle counter and bits 0..3 are event counters 0..3. Writing 1 to a set bit enables that counter. Writing 1 to a clear bit disables it. Writing 0 changes nothing. Both addresses read back the current enable mask, so a write of 0x8000000F enables all five counters.
- R3: Control (address 0) has bit 0 as global enable, bit 3 as divide-by-64 and bit 5 as stop-when-prohibited. Bits 1 and 2 zero all event counters and the cycle counter for one cycle and always read back 0. A counter that is zeroed and would also increment in the same cycle ends at 0. Writing 0x7 therefore zeroes all counters and starts counting, and control then reads 0x1.
- R4: Select (address 3) stores bits 4..0 and reads them back. Event type (address 4, code in bits 7..0) and event count (address 5) reach only the selected counter. With a select value above 3, both read 0 and writes to them are ignored.
- R5: An event counter adds one in each cycle in which all of the following hold: global enable is on, its own enable bit is on, the event input line numbered by its code is high, and at least one authentication input is high. A code at or above the number of event inputs never counts.
- R6: The cycle counter adds one in each cycle in which global enable and bit 31 of the enable mask are on, whatever the authentication inputs are. The exception is when control bit 5 is set and both authentication inputs are low: then the cycle counter holds.
- R7: With control bit 3 set, the cycle counter advances once every 64 counting cycles. Zeroing the cycle counter also restarts this 64-cycle phase.
- R8: Each counter wraps from 0xFFFFFFFF to 0 and sets its own overflow status bit (address 8): bit 31 for the cycle counter, bits 0..3 for the event counters. A status bit stays set until a 1 is written to it.
- R9: When user-access bit 0 (address 7) is clear, an access with `bus_priv` low faults. When it is set, an unprivileged access to address 7 itself still faults. A faulting access sets `bus_fault` with read data 0 and changes no state.
- R10: Authentication status (address 9) reads the invasive input in bit 0 and the non-invasive input in bit 1.
- R11: `bus_ack`, `bus_fault` and `bus_rdata` are registered and appear one cycle after the request. A read returns the register value from before the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | One-cycle access request |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Access is privileged |
| bus_ack | output | 1 | Response valid, one cycle after request |
| bus_rdata | output | 32 | Read data |
| bus_fault | output | 1 | Access was refused |
| dbg_inv_en | input | 1 | Invasive debug authentication |
| dbg_ninv_en | input | 1 | Non-invasive debug authentication |
| evt_in | input | NUM_EVT_IN | Single-cycle event pulses |

## Verification
The bench first turns off both authentication inputs and checks that event counts freeze while the cycle counter keeps running. A design that gated the cycle counter the same way would read a frozen cycle count. It then sets the stop-when-prohibited bit and checks that the cycle counter now holds. Next it pulses an event in the same cycle as a counter-zeroing write. It also writes the cycle counter just below its maximum so it wraps, and writes select values out of range. A design with the wrong priority would read 1 instead of 0, and a missing wrap flag or a leaky select would show up as a wrong read. Finally it makes unprivileged writes with user access off, and reads the target registers back with privilege afterwards. This catches a design that faults but still lets the write through.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int DW    = 32;
  localparam int AW    = 4;
  localparam int SELW  = 5;
  localparam int CODEW = 8;

  localparam logic [AW-1:0] A_CTRL  = 4'd0;
  localparam logic [AW-1:0] A_ENSET = 4'd1;
  localparam logic [AW-1:0] A_ENCLR = 4'd2;
  localparam logic [AW-1:0] A_SEL   = 4'd3;
  localparam logic [AW-1:0] A_TYPE  = 4'd4;
  localparam logic [AW-1:0] A_EVCNT = 4'd5;
  localparam logic [AW-1:0] A_CYC   = 4'd6;
  localparam logic [AW-1:0] A_USER  = 4'd7;
  localparam logic [AW-1:0] A_OVF   = 4'd8;
  localparam logic [AW-1:0] A_AUTH  = 4'd9;

  localparam int C_EN    = 0;
  localparam int C_EVRST = 1;
  localparam int C_CYRST = 2;
  localparam int C_DIV   = 3;
  localparam int C_DP    = 5;
  localparam int CYC_BIT = 31;
endpackage

// File: rtl/perfmon_acl.sv
module perfmon_acl
  import perfmon_pkg::*;
(
  input  logic          req,
  input  logic [AW-1:0] addr,
  input  logic          priv,
  input  logic          user_en,
  output logic          allow,
  output logic          fault
);
  // Unprivileged: refused when user access is off, and always for the user-access register.
  always_comb begin
    fault = req & ~priv & (~user_en | (addr == A_USER));
    allow = req & ~fault;
  end
endmodule

// File: rtl/perfmon_evcnt.sv
module perfmon_evcnt
  import perfmon_pkg::*;
#(
  parameter int NIN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_cnt,
  input  logic             wr_type,
  input  logic [DW-1:0]    wdata,
  input  logic [NIN-1:0]   evt_in,
  input  logic             run,
  output logic [DW-1:0]    cnt,
  output logic [CODEW-1:0] code,
  output logic             wrap
);
  logic hit;
  logic inc;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NIN; i++)
      if (code == CODEW'(i)) hit = evt_in[i];
  end

  assign inc  = run & hit;
  assign wrap = inc & ~clr & ~wr_cnt & (cnt == {DW{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      code <= '0;
    end else begin
      if (wr_type) code <= wdata[CODEW-1:0];
      if (clr)         cnt <= '0;
      else if (wr_cnt) cnt <= wdata;
      else if (inc)    cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/perfmon_cyccnt.sv
module perfmon_cyccnt
  import perfmon_pkg::*;
#(
  parameter int PRE_W = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          run,
  input  logic          div,
  output logic [DW-1:0] cnt,
  output logic          wrap
);
  logic [PRE_W-1:0] pre;
  logic             tick;

  assign tick = run & (~div | (pre == {PRE_W{1'b1}}));
  assign wrap = tick & ~clr & ~wr & (cnt == {DW{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      pre <= '0;
    end else begin
      if (clr)      pre <= '0;
      else if (run) pre <= pre + 1'b1;
      if (clr)       cnt <= '0;
      else if (wr)   cnt <= wdata;
      else if (tick) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
  import perfmon_pkg::*;
#(
  parameter int NUM_CNT    = 4,
  parameter int NUM_EVT_IN = 32,
  parameter int PRE_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_req,
  input  logic                  bus_we,
  input  logic [AW-1:0]         bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  input  logic                  bus_priv,
  output logic                  bus_ack,
  output logic [DW-1:0]         bus_rdata,
  output logic                  bus_fault,
  input  logic                  dbg_inv_en,
  input  logic                  dbg_ninv_en,
  input  logic [NUM_EVT_IN-1:0] evt_in
);
  logic                   allow, fault, wr, rd;
  logic                   ctrl_en, ctrl_div, ctrl_dp;
  logic [NUM_CNT-1:0]     cnt_en;
  logic                   cyc_en;
  logic [SELW-1:0]        sel_q;
  logic                   user_en;
  logic [NUM_CNT-1:0]     ov_ev;
  logic                   ov_cyc;
  logic                   sel_ok, auth_ok;
  logic                   ev_rst, cyc_rst;
  logic [DW-1:0]          ev_cnt [NUM_CNT];
  logic [CODEW-1:0]       ev_code [NUM_CNT];
  logic [NUM_CNT-1:0]     ev_wrap;
  logic [DW*NUM_CNT-1:0]  ev_flat;
  logic [DW-1:0]          cyc_val;
  logic                   cyc_wrap;
  logic [DW-1:0]          en_word, ovf_word, rmux, sel_cnt;
  logic [CODEW-1:0]       sel_code;
  logic                   unused_wdata;

  assign unused_wdata = ^bus_wdata;

  perfmon_acl u_acl (
    .req(bus_req), .addr(bus_addr), .priv(bus_priv), .user_en(user_en),
    .allow(allow), .fault(fault)
  );

  assign wr      = allow & bus_we;
  assign rd      = allow & ~bus_we;
  assign ev_rst  = wr & (bus_addr == A_CTRL) & bus_wdata[C_EVRST];
  assign cyc_rst = wr & (bus_addr == A_CTRL) & bus_wdata[C_CYRST];
  assign sel_ok  = (sel_q < SELW'(NUM_CNT));
  assign auth_ok = dbg_inv_en | dbg_ninv_en;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_ev
    perfmon_evcnt #(.NIN(NUM_EVT_IN)) u_ev (
      .clk(clk), .rst(rst), .clr(ev_rst),
      .wr_cnt(wr & (bus_addr == A_EVCNT) & sel_ok & (sel_q == SELW'(g))),
      .wr_type(wr & (bus_addr == A_TYPE) & sel_ok & (sel_q == SELW'(g))),
      .wdata(bus_wdata), .evt_in(evt_in),
      .run(ctrl_en & cnt_en[g] & auth_ok),
      .cnt(ev_cnt[g]), .code(ev_code[g]), .wrap(ev_wrap[g])
    );
    assign ev_flat[g*DW +: DW] = ev_cnt[g];
  end

  perfmon_cyccnt #(.PRE_W(PRE_W)) u_cyc (
    .clk(clk), .rst(rst), .clr(cyc_rst),
    .wr(wr & (bus_addr == A_CYC)), .wdata(bus_wdata),
    .run(ctrl_en & cyc_en & ~(ctrl_dp & ~auth_ok)),
    .div(ctrl_div), .cnt(cyc_val), .wrap(cyc_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en  <= 1'b0;
      ctrl_div <= 1'b0;
      ctrl_dp  <= 1'b0;
      cnt_en   <= '0;
      cyc_en   <= 1'b0;
      sel_q    <= '0;
      user_en  <= 1'b0;
      ov_ev    <= '0;
      ov_cyc   <= 1'b0;
    end else begin
      if (wr && bus_addr == A_CTRL) begin
        ctrl_en  <= bus_wdata[C_EN];
        ctrl_div <= bus_wdata[C_DIV];
        ctrl_dp  <= bus_wdata[C_DP];
      end
      if (wr && bus_addr == A_ENSET) begin
        cnt_en <= cnt_en | bus_wdata[NUM_CNT-1:0];
        cyc_en <= cyc_en | bus_wdata[CYC_BIT];
      end
      if (wr && bus_addr == A_ENCLR) begin
        cnt_en <= cnt_en & ~bus_wdata[NUM_CNT-1:0];
        cyc_en <= cyc_en & ~bus_wdata[CYC_BIT];
      end
      if (wr && bus_addr == A_SEL)  sel_q   <= bus_wdata[SELW-1:0];
      if (wr && bus_addr == A_USER) user_en <= bus_wdata[0];
      ov_ev  <= (ov_ev & ~((wr && bus_addr == A_OVF) ? bus_wdata[NUM_CNT-1:0] : '0)) | ev_wrap;
      ov_cyc <= (ov_cyc & ~((wr && bus_addr == A_OVF) & bus_wdata[CYC_BIT])) | cyc_wrap;
    end
  end

  always_comb begin
    en_word = '0;
    en_word[NUM_CNT-1:0] = cnt_en;
    en_word[CYC_BIT] = cyc_en;
    ovf_word = '0;
    ovf_word[NUM_CNT-1:0] = ov_ev;
    ovf_word[CYC_BIT] = ov_cyc;
    sel_cnt  = '0;
    sel_code = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (sel_q == SELW'(i)) begin
        sel_cnt  = ev_cnt[i];
        sel_code = ev_code[i];
      end
  end

  always_comb begin
    rmux = '0;
    case (bus_addr)
      A_CTRL: begin
        rmux[C_EN]  = ctrl_en;
        rmux[C_DIV] = ctrl_div;
        rmux[C_DP]  = ctrl_dp;
      end
      A_ENSET, A_ENCLR: rmux = en_word;
      A_SEL:   rmux[SELW-1:0] = sel_q;
      A_TYPE:  rmux[CODEW-1:0] = sel_code;
      A_EVCNT: rmux = sel_cnt;
      A_CYC:   rmux = cyc_val;
      A_USER:  rmux[0] = user_en;
      A_OVF:   rmux = ovf_word;
      A_AUTH:  rmux[1:0] = {dbg_ninv_en, dbg_inv_en};
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_fault <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_req;
      bus_fault <= fault;
      bus_rdata <= rd ? rmux : '0;
    end
  end
endmodule

// File: rtl/perfmon_chk.sv
module perfmon_chk
  import perfmon_pkg::*;
#(
  parameter int NUM_CNT = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_req,
  input logic                  bus_we,
  input logic [AW-1:0]         bus_addr,
  input logic                  bus_priv,
  input logic                  bus_ack,
  input logic                  bus_fault,
  input logic [DW-1:0]         bus_rdata,
  input logic                  dbg_inv_en,
  input logic                  dbg_ninv_en,
  input logic                  user_en,
  input logic                  ctrl_en,
  input logic                  ctrl_dp,
  input logic [DW-1:0]         cyc_val,
  input logic [DW*NUM_CNT-1:0] ev_flat,
  input logic [DW-1:0]         ovf_word
);
  p_ack_follows_req_r11: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> bus_ack);
  p_no_ack_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_req |=> !bus_ack);
  p_fault_zero_data_r9: assert property (@(posedge clk) disable iff (rst)
    bus_fault |-> (bus_rdata == '0));
  p_fault_when_locked_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_priv && !user_en) |=> bus_fault);
  p_rst_bits_read_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && bus_addr == A_CTRL) |=> (bus_rdata[2:1] == 2'b00));
  p_events_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (!dbg_inv_en && !dbg_ninv_en && !bus_req) |=> $stable(ev_flat));
  p_cyc_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && !bus_req) |=> $stable(cyc_val));
  p_cyc_prohibited_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_dp && !dbg_inv_en && !dbg_ninv_en && !bus_req) |=> $stable(cyc_val));
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !bus_req |=> ((ovf_word & $past(ovf_word)) == $past(ovf_word)));
endmodule

bind perfmon_unit perfmon_chk #(.NUM_CNT(NUM_CNT)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_priv(bus_priv), .bus_ack(bus_ack),
  .bus_fault(bus_fault), .bus_rdata(bus_rdata),
  .dbg_inv_en(dbg_inv_en), .dbg_ninv_en(dbg_ninv_en),
  .user_en(user_en), .ctrl_en(ctrl_en), .ctrl_dp(ctrl_dp),
  .cyc_val(cyc_val), .ev_flat(ev_flat), .ovf_word(ovf_word)
);

// File: tb/perfmon_unit_tb.sv
module perfmon_unit_tb;
  localparam int NIN = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           bus_req = 1'b0, bus_we = 1'b0, bus_priv = 1'b1;
  logic [3:0]     bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic           bus_ack, bus_fault;
  logic [31:0]    bus_rdata;
  logic           dbg_inv_en = 1'b1, dbg_ninv_en = 1'b1;
  logic [NIN-1:0] evt_in = '0;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  reported = 1'b0;

  typedef struct {
    logic [31:0] data;
    logic        flt;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  perfmon_unit #(.NUM_CNT(4), .NUM_EVT_IN(NIN)) u_dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_priv(bus_priv),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_fault(bus_fault),
    .dbg_inv_en(dbg_inv_en), .dbg_ninv_en(dbg_ninv_en), .evt_in(evt_in)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    end
  endtask

  // Monitor: pops one expected item per response.
  always @(negedge clk) begin
    if (!rst && bus_ack) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected ack", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(bus_rdata == e.data, e.tag, bus_rdata, e.data);
        check(bus_fault == e.flt, {e.tag, " fault"}, {31'd0, bus_fault}, {31'd0, e.flt});
      end
    end
  end

  task automatic acc(input bit we, input logic [3:0] a, input logic [31:0] d,
                     input bit pv, input logic [31:0] ed, input bit ef, input string tag);
    exp_t e;
    e.data = ed; e.flt = ef; e.tag = tag;
    exp_q.push_back(e);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; bus_priv = pv;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_priv = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    acc(1'b1, a, d, 1'b1, 32'd0, 1'b0, tag);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    acc(1'b0, a, 32'd0, 1'b1, e, 1'b0, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [NIN-1:0] m, input int n);
    evt_in = m;
    repeat (n) @(negedge clk);
    evt_in = '0;
  endtask

  initial begin
    #(20 * 100000);
    check(1'b0, "watchdog", 32'd1, 32'd0);
    report();
    $finish;
  end

  initial begin
    idle(4);
    check(bus_ack == 1'b0, "R1 ack in reset", {31'd0, bus_ack}, 32'd0);
    rst = 1'b0;
    idle(1);
    check(bus_ack == 1'b0, "R1 ack idle", {31'd0, bus_ack}, 32'd0);
    rd(4'd0, 32'd0, "R1 ctrl");
    rd(4'd1, 32'd0, "R1 enable");
    rd(4'd6, 32'd0, "R1 cycle");
    rd(4'd5, 32'd0, "R1 event0");
    rd(4'd8, 32'd0, "R1 overflow");
    idle(1);
    check(bus_ack == 1'b0, "R11 no ack idle", {31'd0, bus_ack}, 32'd0);

    // R10 authentication status
    dbg_inv_en = 1'b1; dbg_ninv_en = 1'b0;
    rd(4'd9, 32'd1, "R10 inv only");
    dbg_inv_en = 1'b0; dbg_ninv_en = 1'b1;
    rd(4'd9, 32'd2, "R10 ninv only");
    dbg_inv_en = 1'b1;
    rd(4'd9, 32'd3, "R10 both");

    // R2 enable set and clear
    wr(4'd1, 32'h8000000F, "R2 set all");
    rd(4'd1, 32'h8000000F, "R2 mask all");
    wr(4'd2, 32'h00000002, "R2 clear one");
    rd(4'd2, 32'h8000000D, "R2 mask after clear");
    wr(4'd1, 32'h00000002, "R2 set one");
    rd(4'd1, 32'h8000000F, "R2 mask restored");

    // R6 cycle counter runs: 10 counting edges
    wr(4'd0, 32'h5, "R6 start");
    idle(9);
    wr(4'd0, 32'h0, "R6 stop");
    rd(4'd6, 32'd10, "R6 cycle count");
    // R6 runs without authentication
    dbg_inv_en = 1'b0; dbg_ninv_en = 1'b0;
    wr(4'd0, 32'h5, "R6 start noauth");
    idle(4);
    wr(4'd0, 32'h0, "R6 stop noauth");
    rd(4'd6, 32'd5, "R6 cycle noauth");
    // R6 stop-when-prohibited
    wr(4'd0, 32'h25, "R6 start dp");
    idle(4);
    wr(4'd0, 32'h20, "R6 stop dp");
    rd(4'd6, 32'd0, "R6 cycle held by dp");
    rd(4'd0, 32'h20, "R3 ctrl dp readback");
    wr(4'd0, 32'h0, "R6 clear dp");
    dbg_inv_en = 1'b1; dbg_ninv_en = 1'b1;

    // R7 divide by 64: 130 counting edges -> 2
    wr(4'd0, 32'hD, "R7 start div");
    idle(129);
    wr(4'd0, 32'h0, "R7 stop div");
    rd(4'd6, 32'd2, "R7 divided count");

    // R4 / R5 event codes
    wr(4'd3, 32'd0, "R4 sel0");  wr(4'd4, 32'd3, "R4 type0");
    wr(4'd3, 32'd1, "R4 sel1");  wr(4'd4, 32'd5, "R4 type1");
    wr(4'd3, 32'd2, "R4 sel2");  wr(4'd4, 32'd200, "R4 type2");
    wr(4'd3, 32'd3, "R4 sel3");  wr(4'd4, 32'd3, "R4 type3");
    wr(4'd0, 32'h3, "R5 start");
    pulse(32'h8, 4);
    pulse(32'h20, 2);
    pulse('1, 1);
    wr(4'd0, 32'h0, "R5 stop");
    wr(4'd3, 32'd0, "R4 sel0"); rd(4'd5, 32'd5, "R5 counter0");
    wr(4'd3, 32'd1, "R4 sel1"); rd(4'd5, 32'd3, "R5 counter1");
    rd(4'd4, 32'd5, "R4 type1 readback");
    wr(4'd3, 32'd2, "R4 sel2"); rd(4'd5, 32'd0, "R5 code out of range");
    wr(4'd3, 32'd3, "R4 sel3"); rd(4'd5, 32'd5, "R5 counter3");

    // R5 gating by authentication
    wr(4'd3, 32'd0, "R4 sel0");
    dbg_inv_en = 1'b0; dbg_ninv_en = 1'b0;
    wr(4'd0, 32'h1, "R5 start noauth");
    pulse(32'h8, 3);
    wr(4'd0, 32'h0, "R5 stop noauth");
    rd(4'd5, 32'd5, "R5 frozen without auth");
    dbg_ninv_en = 1'b1;
    wr(4'd0, 32'h1, "R5 start ninv");
    pulse(32'h8, 2);
    wr(4'd0, 32'h0, "R5 stop ninv");
    rd(4'd5, 32'd7, "R5 counts with ninv");
    dbg_inv_en = 1'b1;

    // R4 select out of range
    wr(4'd3, 32'd7, "R4 sel7");
    rd(4'd5, 32'd0, "R4 count reads zero");
    rd(4'd4, 32'd0, "R4 type reads zero");
    wr(4'd5, 32'h1234, "R4 ignored write");
    rd(4'd3, 32'd7, "R4 select readback");
    wr(4'd3, 32'd0, "R4 sel0");
    rd(4'd5, 32'd7, "R4 counter0 untouched");

    // R3 reset bits and priority
    wr(4'd0, 32'h7, "R3 reset and start");
    rd(4'd0, 32'h1, "R3 reset bits read zero");
    wr(4'd0, 32'h5, "R3 cycle reset while running");
    wr(4'd0, 32'h0, "R3 stop");
    rd(4'd6, 32'd1, "R3 cycle reset beats increment");
    wr(4'd0, 32'h1, "R3 start");
    evt_in = '1;
    wr(4'd0, 32'h3, "R3 event reset with pulse");
    evt_in = '0;
    wr(4'd0, 32'h0, "R3 stop");
    rd(4'd5, 32'd0, "R3 event reset beats increment");

    // R11 read returns pre-edge value
    wr(4'd0, 32'h5, "R11 start");
    rd(4'd6, 32'd0, "R11 read before update");
    wr(4'd0, 32'h0, "R11 stop");
    rd(4'd6, 32'd2, "R11 later count");

    // R8 wrap and overflow
    wr(4'd5, 32'hFFFFFFFE, "R8 preset event");
    wr(4'd0, 32'h1, "R8 start");
    pulse(32'h8, 2);
    wr(4'd0, 32'h0, "R8 stop");
    rd(4'd5, 32'd0, "R8 event wrapped");
    rd(4'd8, 32'h1, "R8 event flag");
    wr(4'd8, 32'h80000000, "R8 clear other bit");
    rd(4'd8, 32'h1, "R8 flag sticky");
    wr(4'd8, 32'h1, "R8 clear flag");
    rd(4'd8, 32'h0, "R8 flag cleared");
    wr(4'd6, 32'hFFFFFFF0, "R8 preset cycle");
    wr(4'd0, 32'h1, "R8 start cycle");
    idle(16);
    wr(4'd0, 32'h0, "R8 stop cycle");
    rd(4'd6, 32'd1, "R8 cycle wrapped");
    rd(4'd8, 32'h80000000, "R8 cycle flag");

    // R9 user access
    acc(1'b1, 4'd0, 32'h1, 1'b0, 32'd0, 1'b1, "R9 user write faults");
    rd(4'd0, 32'h0, "R9 ctrl unchanged");
    acc(1'b0, 4'd6, 32'd0, 1'b0, 32'd0, 1'b1, "R9 user read faults");
    wr(4'd7, 32'h1, "R9 enable user");
    acc(1'b0, 4'd6, 32'd0, 1'b0, 32'd1, 1'b0, "R9 user read allowed");
    acc(1'b1, 4'd7, 32'h0, 1'b0, 32'd0, 1'b1, "R9 user enable write faults");
    rd(4'd7, 32'h1, "R9 user enable unchanged");

    idle(3);
    check(exp_q.size() == 0, "R11 all responses seen", exp_q.size(), 32'd0);
    report();
    $finish;
  end
endmodule